// File: doc/BRIEF.md
# Debug Communications Channel Mailbox

A two-way, one-word mailbox between an external debugger and software on the processor core. Each direction has one 32-bit holding register and a "full" flag. Words that the core writes are read by the debugger. Words that the debugger writes are read by the core. The debugger reaches the block through register access strobes and a 5-bit register address, as a scan-chain access unit would issue them. The core uses a plain write port, a plain read port and the two flags.

Both flags appear in a read-only status word. The top nibble of that word holds a fixed version code. A debugger can stream words without polling, because it assumes the core software keeps up. It can also poll the status word until the flag it needs changes. A debugger read of the data register consumes the pending word. Because of this, a protocol must not read the data register more often than it means to.

Top module: `dcc_mailbox`

## Requirements
- R1: A synchronous active-high `rst` clears both full flags, both holding registers and both overflow outputs.
- R2: At address 4, `dbg_rdata` shows the status word. Bit 0 is the debugger-to-core full flag. Bit 1 is the core-to-debugger full flag. Bits 31:28 hold the `VERSION` parameter (default 6). All other bits read 0.
- R3: A `core_tx_wr` while `core_tx_full` is low loads `core_tx_data` and sets `core_tx_full` on the next cycle. While `dbg_addr` is 5, `dbg_rdata` shows the held core-to-debugger word, whether or not a strobe is present.
- R4: `dbg_rd` with `dbg_addr` = 5 consumes the core-to-debugger word, and `core_tx_full` is low on the next cycle. Such a read with the flag already low changes nothing.
- R5: `dbg_wr` with `dbg_addr` = 5 while `core_rx_full` is low loads `dbg_wdata`. On the next cycle `core_rx_full` is set and `core_rx_data` shows the word.
- R6: `core_rx_rd` while `core_rx_full` is high clears the flag on the next cycle. `core_rx_rd` while the flag is low has no effect.
- R7: A write into a direction whose flag is already set, and which is not being drained in the same cycle, is dropped and the held word stays. The overflow output of that direction (`tx_overflow` or `rx_overflow`) rises on the next cycle and stays high until reset.
- R8: A status read, a write to address 4, and any access to an address other than 4 or 5 leave both flags and both words unchanged.
- R9: A core write in the same cycle as a debugger read of the data register replaces the word. `core_tx_full` stays high and no overflow is raised. The same applies to a debugger write in the same cycle as `core_rx_rd`.
- R10: For any address other than 4 and 5, `dbg_rdata` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_rd | input | 1 | Debugger register read strobe |
| dbg_wr | input | 1 | Debugger register write strobe |
| dbg_addr | input | 5 | Debugger register address |
| dbg_wdata | input | 32 | Debugger write data |
| dbg_rdata | output | 32 | Debugger read data, combinational from `dbg_addr` |
| core_tx_wr | input | 1 | Core writes a word for the debugger |
| core_tx_data | input | 32 | Word from the core |
| core_tx_full | output | 1 | Core-to-debugger word pending |
| core_rx_rd | input | 1 | Core takes the word from the debugger |
| core_rx_data | output | 32 | Word from the debugger |
| core_rx_full | output | 1 | Debugger-to-core word pending |
| tx_overflow | output | 1 | Sticky: a core write was dropped |
| rx_overflow | output | 1 | Sticky: a debugger write was dropped |

## Verification
A wrong flag shows up on the flag ports and in the status word one cycle after the strobe that should have changed it. A lost or stale holding register shows up on `dbg_rdata` or `core_rx_data` in the same cycle. A read that consumes when it should not, or a write that overwrites when it should not, leaves the flags or the held word different from what the requirements predict at the very next sample. The overflow bits are sticky, so one wrong drop stays visible at the ports until reset.

// File: rtl/dcc_mailbox_pkg.sv
package dcc_mailbox_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned VER_W  = 4;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_DATA   = 2'd2
    } dbg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        dbg_sel_e sel;
    } dbg_access_t;

    // Status word: flags in the low bits, version in the top nibble.
    function automatic logic [WORD_W-1:0] pack_status(
        input logic [VER_W-1:0] ver,
        input logic             to_core_full,
        input logic             to_dbg_full
    );
        logic [WORD_W-1:0] s;
        s = '0;
        s[0] = to_core_full;
        s[1] = to_dbg_full;
        s[WORD_W-1 -: VER_W] = ver;
        return s;
    endfunction

endpackage

// File: rtl/dcc_slot.sv
module dcc_slot #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fill,
    input  logic [W-1:0] fill_word,
    input  logic         drain,
    output logic         full,
    output logic [W-1:0] word,
    output logic         ovf
);
    logic accept;

    // A drain in the same cycle frees the slot for the new word.
    assign accept = fill && (!full || drain);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
            ovf  <= 1'b0;
        end else begin
            if (accept) begin
                word <= fill_word;
                full <= 1'b1;
            end else if (drain) begin
                full <= 1'b0;
            end
            if (fill && !accept) begin
                ovf <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dcc_dbg_port.sv
module dcc_dbg_port
    import dcc_mailbox_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 5,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 4,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 5
) (
    input  logic              dbg_rd,
    input  logic              dbg_wr,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic [WORD_W-1:0] status_word,
    input  logic [WORD_W-1:0] to_dbg_word,
    output logic [WORD_W-1:0] rdata,
    output logic              data_rd,
    output logic              data_wr
);
    dbg_access_t acc;

    always_comb begin
        acc.rd = dbg_rd;
        acc.wr = dbg_wr;
        if (dbg_addr == STATUS_ADDR)    acc.sel = SEL_STATUS;
        else if (dbg_addr == DATA_ADDR) acc.sel = SEL_DATA;
        else                            acc.sel = SEL_NONE;
    end

    always_comb begin
        unique case (acc.sel)
            SEL_STATUS: rdata = status_word;
            SEL_DATA:   rdata = to_dbg_word;
            default:    rdata = '0;
        endcase
    end

    // Only the data register has side effects; status is read-only.
    assign data_rd = acc.rd && (acc.sel == SEL_DATA);
    assign data_wr = acc.wr && (acc.sel == SEL_DATA);
endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox
    import dcc_mailbox_pkg::*;
#(
    parameter int unsigned      ADDR_W      = 5,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 4,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 5,
    parameter logic [VER_W-1:0] VERSION     = 4'd6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_rd,
    input  logic              dbg_wr,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic [WORD_W-1:0] dbg_wdata,
    output logic [WORD_W-1:0] dbg_rdata,
    input  logic              core_tx_wr,
    input  logic [WORD_W-1:0] core_tx_data,
    output logic              core_tx_full,
    input  logic              core_rx_rd,
    output logic [WORD_W-1:0] core_rx_data,
    output logic              core_rx_full,
    output logic              tx_overflow,
    output logic              rx_overflow
);
    localparam int unsigned N_DIR   = 2;
    localparam int unsigned DIR_C2D = 0;
    localparam int unsigned DIR_D2C = 1;

    logic [N_DIR-1:0]  fill_v, drain_v, full_v, ovf_v;
    logic [WORD_W-1:0] in_w  [N_DIR];
    logic [WORD_W-1:0] out_w [N_DIR];
    logic              data_rd, data_wr;
    logic [WORD_W-1:0] status_word;

    assign status_word = pack_status(VERSION, full_v[DIR_D2C], full_v[DIR_C2D]);

    dcc_dbg_port #(
        .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
    ) u_port (
        .dbg_rd     (dbg_rd),
        .dbg_wr     (dbg_wr),
        .dbg_addr   (dbg_addr),
        .status_word(status_word),
        .to_dbg_word(out_w[DIR_C2D]),
        .rdata      (dbg_rdata),
        .data_rd    (data_rd),
        .data_wr    (data_wr)
    );

    assign fill_v[DIR_C2D]  = core_tx_wr;
    assign in_w[DIR_C2D]    = core_tx_data;
    assign drain_v[DIR_C2D] = data_rd;
    assign fill_v[DIR_D2C]  = data_wr;
    assign in_w[DIR_D2C]    = dbg_wdata;
    assign drain_v[DIR_D2C] = core_rx_rd;

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        dcc_slot #(.W(WORD_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .fill     (fill_v[d]),
            .fill_word(in_w[d]),
            .drain    (drain_v[d]),
            .full     (full_v[d]),
            .word     (out_w[d]),
            .ovf      (ovf_v[d])
        );
    end

    assign core_tx_full = full_v[DIR_C2D];
    assign tx_overflow  = ovf_v[DIR_C2D];
    assign core_rx_full = full_v[DIR_D2C];
    assign core_rx_data = out_w[DIR_D2C];
    assign rx_overflow  = ovf_v[DIR_D2C];
endmodule

// File: rtl/dcc_mailbox_chk.sv
module dcc_mailbox_chk
    import dcc_mailbox_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 5,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 4,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 5,
    parameter logic [VER_W-1:0]  VERSION     = 4'd6
) (
    input logic              clk,
    input logic              rst,
    input logic              dbg_rd,
    input logic              dbg_wr,
    input logic [ADDR_W-1:0] dbg_addr,
    input logic [WORD_W-1:0] dbg_wdata,
    input logic [WORD_W-1:0] dbg_rdata,
    input logic              core_tx_wr,
    input logic              core_tx_full,
    input logic              core_rx_rd,
    input logic [WORD_W-1:0] core_rx_data,
    input logic              core_rx_full,
    input logic              tx_overflow,
    input logic              rx_overflow
);
    logic dwr, drd;
    assign dwr = dbg_wr && (dbg_addr == DATA_ADDR);
    assign drd = dbg_rd && (dbg_addr == DATA_ADDR);

    p_status_layout_r2: assert property (@(posedge clk) disable iff (rst)
        (dbg_addr == STATUS_ADDR) |-> (dbg_rdata[0] == core_rx_full &&
            dbg_rdata[1] == core_tx_full && dbg_rdata[WORD_W-1 -: VER_W] == VERSION));

    p_tx_set_r3: assert property (@(posedge clk) disable iff (rst)
        (core_tx_wr && !core_tx_full) |=> core_tx_full);

    p_tx_drain_r4: assert property (@(posedge clk) disable iff (rst)
        (drd && !core_tx_wr) |=> !core_tx_full);

    p_rx_set_r5: assert property (@(posedge clk) disable iff (rst)
        (dwr && !core_rx_full) |=> (core_rx_full && core_rx_data == $past(dbg_wdata)));

    p_rx_drain_r6: assert property (@(posedge clk) disable iff (rst)
        (core_rx_rd && !dwr) |=> !core_rx_full);

    p_rx_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (core_rx_full && !core_rx_rd) |=> $stable(core_rx_data));

    p_tx_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        tx_overflow |=> tx_overflow);

    p_rx_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        rx_overflow |=> rx_overflow);

    p_side_free_r8: assert property (@(posedge clk) disable iff (rst)
        (dbg_addr != DATA_ADDR && !core_tx_wr && !core_rx_rd) |=>
            ($stable(core_tx_full) && $stable(core_rx_full) && $stable(core_rx_data)));

    p_refill_r9: assert property (@(posedge clk) disable iff (rst)
        (drd && core_tx_wr && core_tx_full && !tx_overflow) |=> (core_tx_full && !tx_overflow));

    p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
        (dbg_addr != STATUS_ADDR && dbg_addr != DATA_ADDR) |-> (dbg_rdata == '0));
endmodule

bind dcc_mailbox dcc_mailbox_chk #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR), .VERSION(VERSION)
) u_chk (
    .clk(clk), .rst(rst), .dbg_rd(dbg_rd), .dbg_wr(dbg_wr), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .core_tx_wr(core_tx_wr),
    .core_tx_full(core_tx_full), .core_rx_rd(core_rx_rd), .core_rx_data(core_rx_data),
    .core_rx_full(core_rx_full), .tx_overflow(tx_overflow), .rx_overflow(rx_overflow)
);

// File: tb/dcc_mailbox_test.sv
module dcc_mailbox_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbg_rd = 0, dbg_wr = 0;
    logic [4:0]  dbg_addr = 0;
    logic [31:0] dbg_wdata = 0;
    logic [31:0] dbg_rdata;
    logic        core_tx_wr = 0;
    logic [31:0] core_tx_data = 0;
    logic        core_tx_full;
    logic        core_rx_rd = 0;
    logic [31:0] core_rx_data;
    logic        core_rx_full;
    logic        tx_overflow, rx_overflow;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // expected state, from the requirements
    logic        m_txf, m_rxf, m_txo, m_rxo;
    logic [31:0] m_txd, m_rxd;

    always #4 clk = ~clk;

    dcc_mailbox uut (
        .clk(clk), .rst(rst), .dbg_rd(dbg_rd), .dbg_wr(dbg_wr), .dbg_addr(dbg_addr),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .core_tx_wr(core_tx_wr),
        .core_tx_data(core_tx_data), .core_tx_full(core_tx_full), .core_rx_rd(core_rx_rd),
        .core_rx_data(core_rx_data), .core_rx_full(core_rx_full),
        .tx_overflow(tx_overflow), .rx_overflow(rx_overflow)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rdata(input logic [4:0] a);
        if (a == 5'd4) return {4'd6, 26'd0, m_txf, m_rxf};
        if (a == 5'd5) return m_txd;
        return 32'd0;
    endfunction

    task automatic model_reset();
        m_txf = 0; m_rxf = 0; m_txo = 0; m_rxo = 0; m_txd = 0; m_rxd = 0;
    endtask

    task automatic model_step();
        bit tdr, rfl, tacc, racc;
        tdr  = dbg_rd && dbg_addr == 5'd5;
        rfl  = dbg_wr && dbg_addr == 5'd5;
        tacc = core_tx_wr && (!m_txf || tdr);
        racc = rfl && (!m_rxf || core_rx_rd);
        if (core_tx_wr && !tacc) m_txo = 1;
        if (rfl && !racc) m_rxo = 1;
        if (tacc) begin m_txd = core_tx_data; m_txf = 1; end
        else if (tdr) m_txf = 0;
        if (racc) begin m_rxd = dbg_wdata; m_rxf = 1; end
        else if (core_rx_rd) m_rxf = 0;
    endtask

    task automatic check_state();
        check(core_tx_full == m_txf, "R3/R4 tx flag", 32'(core_tx_full), 32'(m_txf));
        check(core_rx_full == m_rxf, "R5/R6 rx flag", 32'(core_rx_full), 32'(m_rxf));
        check(core_rx_data == m_rxd, "R5 rx word", core_rx_data, m_rxd);
        check(tx_overflow == m_txo, "R7 tx overflow", 32'(tx_overflow), 32'(m_txo));
        check(rx_overflow == m_rxo, "R7 rx overflow", 32'(rx_overflow), 32'(m_rxo));
    endtask

    // one cycle: drive at negedge, check read mux, clock, check state
    task automatic step(input bit rd, input bit wr, input logic [4:0] a, input logic [31:0] wd,
                        input bit ctw, input logic [31:0] ctd, input bit crr);
        string tag;
        @(negedge clk);
        dbg_rd = rd; dbg_wr = wr; dbg_addr = a; dbg_wdata = wd;
        core_tx_wr = ctw; core_tx_data = ctd; core_rx_rd = crr;
        #1;
        tag = (a == 5'd4) ? "R2 status" : (a == 5'd5) ? "R3 data read" : "R10 unmapped";
        check(dbg_rdata == exp_rdata(a), tag, dbg_rdata, exp_rdata(a));
        @(posedge clk);
        model_step();
        #1;
        check_state();
    endtask

    task automatic idle();
        step(0, 0, 5'd0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        check(!core_tx_full && !core_rx_full, "R1 flags after reset", {30'd0, core_tx_full, core_rx_full}, 0);
        check(core_rx_data == 0 && !tx_overflow && !rx_overflow, "R1 word/ovf after reset", core_rx_data, 0);
        dbg_addr = 5'd5; #1;
        check(dbg_rdata == 0, "R1 tx word after reset", dbg_rdata, 0);
        dbg_addr = 5'd4; #1;
        check(dbg_rdata == 32'h6000_0000, "R2 status after reset", dbg_rdata, 32'h6000_0000);

        // R3: core fills, debugger peeks without consuming
        step(0, 0, 5'd4, 0, 1, 32'hA5A5_0001, 0);
        check(core_tx_full == 1, "R3 flag set", 32'(core_tx_full), 1);
        step(0, 0, 5'd5, 0, 0, 0, 0);
        // R8: repeated status reads keep the flag
        step(1, 0, 5'd4, 0, 0, 0, 0);
        step(1, 0, 5'd4, 0, 0, 0, 0);
        check(core_tx_full == 1, "R8 status read keeps flag", 32'(core_tx_full), 1);
        // R4: consuming read
        step(1, 0, 5'd5, 0, 0, 0, 0);
        check(core_tx_full == 0, "R4 read consumes", 32'(core_tx_full), 0);
        step(1, 0, 5'd5, 0, 0, 0, 0);
        check(core_tx_full == 0 && !tx_overflow, "R4 over-read harmless", 32'(core_tx_full), 0);

        // R5 / R7: debugger fill, then overfill
        step(0, 1, 5'd5, 32'h1234_5678, 0, 0, 0);
        check(core_rx_full && core_rx_data == 32'h1234_5678, "R5 rx loaded", core_rx_data, 32'h1234_5678);
        step(0, 1, 5'd5, 32'hDEAD_BEEF, 0, 0, 0);
        check(core_rx_data == 32'h1234_5678 && rx_overflow, "R7 dropped write", core_rx_data, 32'h1234_5678);
        // R6: core drain, then drain when empty
        step(0, 0, 5'd0, 0, 0, 0, 1);
        check(core_rx_full == 0, "R6 core read clears", 32'(core_rx_full), 0);
        step(0, 0, 5'd0, 0, 0, 0, 1);
        check(core_rx_full == 0 && rx_overflow, "R6/R7 empty drain, sticky ovf", 32'(core_rx_full), 0);

        // R8: writes to status and to unmapped address
        step(0, 1, 5'd4, 32'hFFFF_FFFF, 0, 0, 0);
        step(1, 1, 5'd9, 32'hFFFF_FFFF, 0, 0, 0);
        check(!core_rx_full && !core_tx_full, "R8 no side effect", {30'd0, core_tx_full, core_rx_full}, 0);

        // R9: simultaneous drain and fill, both directions
        step(0, 0, 5'd0, 0, 1, 32'h0000_00D1, 0);
        step(1, 0, 5'd5, 0, 1, 32'h0000_00E2, 0);
        check(core_tx_full && !tx_overflow, "R9 tx refill", {30'd0, tx_overflow, core_tx_full}, 1);
        step(0, 0, 5'd5, 0, 0, 0, 0);
        step(0, 1, 5'd5, 32'h0000_0077, 0, 0, 0);
        step(0, 1, 5'd5, 32'h0000_0088, 0, 0, 1);
        check(core_rx_full && core_rx_data == 32'h88, "R9 rx refill", core_rx_data, 32'h88);

        // random traffic
        for (int i = 0; i < 600; i++) begin
            logic [4:0] a;
            int unsigned pick;
            pick = $urandom_range(0, 9);
            a = (pick < 4) ? 5'd5 : (pick < 7) ? 5'd4 : 5'($urandom_range(0, 31));
            step($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, a, $urandom,
                 $urandom_range(0, 3) == 0, $urandom, $urandom_range(0, 2) == 0);
        end

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst = 1;
        @(posedge clk); #1;
        model_reset();
        rst = 0;
        check_state();
        check(!tx_overflow && !rx_overflow, "R1 reset clears ovf", {30'd0, tx_overflow, rx_overflow}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule